// File: doc/BRIEF.md
# Serial Pin Shift Slice

This block drives or samples one chip pin as a timed serial bit stream, so that software never has to toggle the pin by hand. A 32-bit working register moves one bit per shift event. A second 32-bit register can be filled by software while the working register shifts. A prescaler sets the spacing between shift events, and a bit counter sets how many events make up one word. When a word ends, the prepared word takes the place of the working one in the same clock edge. A 32-bit enable word moves in step with the data, so each bit on the pin can be driven high, driven low or left floating.

Software programs the block through a small word-wide register port: a write strobe with an address, and an address-selected read path. In transmit mode the pin carries the most significant bit of the working register. In capture mode the pin is sampled on every shift event, and each finished word is placed where software can read it. A sticky completion flag drives an interrupt line. A sticky underrun flag records that a word ended before software had supplied a new one. A divided clock, which toggles on every shift event, is also brought out, so the same slice can supply a companion serial clock.

Top module: `pin_stream_slice`

## Requirements
- R1: After reset, every output is low and all eight register addresses read back as zero.
- R2: While the run bit (address 0 bit 0) is set, shift events occur every P+1 clock cycles, where P is the prescale value at address 1 bits 15:0. The first event comes P+1 cycles after run is set. `shift_clk_o` toggles on each shift event and is held low while stopped.
- R3: A word ends on the (B+1)-th shift event, where B is the field at address 2 bits 4:0. The counter then restarts from the current value of B.
- R4: In transmit mode (address 0 bit 1 clear), `pin_out_o` shows bit 31 of the working data (address 6). Each shift event moves that register one place toward bit 31 and fills bit 0 with zero.
- R5: In transmit mode while running, `pin_oe_o` shows bit 31 of the working enable word (address 7). That word shifts together with the data, so each enable bit goes out in the same cycle as its data bit. `pin_oe_o` is low while stopped.
- R6: On the last shift event of a word in transmit mode, the prepared data (address 3) and prepared enable (address 4) are copied into the working registers at that same edge. The pending bit (address 5 bit 2) is also cleared, unless software writes address 3 in that same cycle, in which case the write sets it.
- R7: If a transmit word ends while the pending bit is clear, the underrun flag (address 5 bit 1) is set and stays set. The stale prepared word is reused.
- R8: In capture mode, each shift event shifts the pin value into bit 0 of the working data. On the last event the finished word, including that final bit, is written to address 3 and the working data is cleared. `pin_out_o` and `pin_oe_o` stay low in capture mode.
- R9: Every word end sets the done flag (address 5 bit 0), and `done_irq_o` follows that flag. Writing ones to address 5 clears the matching flags, but a word end in the same cycle keeps done set.
- R10: Writes to addresses 6 and 7 have no effect while the run bit is set.
- R11: Addresses 0, 1, 2 and 4 read back the last value written to their fields. A write to address 3 sets the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data for rd_addr_i |
| pin_in_i | input | 1 | Pin level sampled in capture mode |
| pin_out_o | output | 1 | Pin drive level |
| pin_oe_o | output | 1 | Pin drive enable; low floats the pin |
| shift_clk_o | output | 1 | Divided clock toggling on each shift event |
| done_irq_o | output | 1 | Word-complete interrupt |

## Verification
The hardest cases to reach are a word end that falls in the same cycle as a software write, either a refill of the prepared word or a write-one clear of the status flags, because the outcome depends on which update wins. Short prescale values and a one-bit word length make word ends happen in almost every cycle. Long runs of random register writes, with random pin levels, then land such writes on swap edges many times. A reference model in the bench follows every register and output each cycle.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_RATE   = 3'd1,
    ADR_BITS   = 3'd2,
    ADR_PREP   = 3'd3,
    ADR_PREPOE = 3'd4,
    ADR_STAT   = 3'd5,
    ADR_WORK   = 3'd6,
    ADR_WORKOE = 3'd7
  } bsl_addr_e;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_CAP = 1;
  localparam int unsigned ST_DONE  = 0;
  localparam int unsigned ST_UNDER = 1;
  localparam int unsigned ST_PEND  = 2;
endpackage

// File: rtl/bsl_rate_div.sv
module bsl_rate_div #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] preset_i,
  output logic              strobe_o,
  output logic              sclk_o
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              sclk_q, sclk_d;

  assign strobe_o = run_i && (cnt_q == '0);
  assign sclk_o   = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = preset_i;
      sclk_d = 1'b0;
    end else if (strobe_o) begin
      cnt_d  = preset_i;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  // R2: no back-to-back events unless the prescale is zero
  assert_event_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(strobe_o) && run_i && $past(run_i) && $past(preset_i) != '0) |-> !strobe_o);
  // R2: divided clock changes exactly after shift events
  assert_sclk_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> ((sclk_o != $past(sclk_o)) == $past(strobe_o)));
endmodule

// File: rtl/bsl_bit_count.sv
module bsl_bit_count #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last_o = strobe_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)        cnt_d = preset_i;
    else if (last_o)   cnt_d = preset_i;
    else if (strobe_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3: the count restarts from the programmed length after a word end
  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(last_o) && $past(run_i)) |-> (cnt_q == $past(preset_i)));
endmodule

// File: rtl/bsl_shift_core.sv
module bsl_shift_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cap_i,
  input  logic              strobe_i,
  input  logic              last_i,
  input  logic              pin_i,
  input  logic              ld_data_i,
  input  logic              ld_oe_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic [DATA_W-1:0] prep_i,
  input  logic [DATA_W-1:0] prep_oe_i,
  output logic [DATA_W-1:0] work_o,
  output logic [DATA_W-1:0] work_oe_o,
  output logic [DATA_W-1:0] cap_word_o,
  output logic              pin_out_o,
  output logic              pin_oe_o
);
  logic [DATA_W-1:0] data_q, data_d, oe_q, oe_d;

  assign cap_word_o = {data_q[DATA_W-2:0], pin_i};
  assign work_o     = data_q;
  assign work_oe_o  = oe_q;
  assign pin_out_o  = !cap_i && data_q[DATA_W-1];
  assign pin_oe_o   = run_i && !cap_i && oe_q[DATA_W-1];

  always_comb begin
    data_d = data_q;
    oe_d   = oe_q;
    if (ld_data_i) data_d = ld_val_i;
    if (ld_oe_i)   oe_d   = ld_val_i;
    if (strobe_i) begin
      if (cap_i) begin
        data_d = last_i ? '0 : cap_word_o;
      end else if (last_i) begin
        data_d = prep_i;
        oe_d   = prep_oe_i;
      end else begin
        data_d = {data_q[DATA_W-2:0], 1'b0};
        oe_d   = {oe_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= '0;
    end else begin
      data_q <= data_d;
      oe_q   <= oe_d;
    end
  end

  // R6: swap takes the prepared pair at the final event
  assert_swap_loads_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && !cap_i) |=> (data_q == $past(prep_i) && oe_q == $past(prep_oe_i)));
  // R10: working registers only move on shift events while running
  assert_work_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !strobe_i) |=> ($stable(data_q) && $stable(oe_q)));
  // R8: capture mode never drives the pin
  assert_capture_floats_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> (!pin_oe_o && !pin_out_o));
endmodule

// File: rtl/pin_stream_slice.sv
module pin_stream_slice
  import bsl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              pin_in_i,
  output logic              pin_out_o,
  output logic              pin_oe_o,
  output logic              shift_clk_o,
  output logic              done_irq_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic              run_q, run_d, cap_q, cap_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [CNT_W-1:0]  bits_q, bits_d;
  logic [DATA_W-1:0] prep_q, prep_d, prepoe_q, prepoe_d;
  logic              done_q, done_d, und_q, und_d, pend_q, pend_d;
  logic              strobe, swap;
  logic [DATA_W-1:0] work, work_oe, cap_word;
  logic              we_ctrl, we_rate, we_bits, we_prep, we_prepoe, we_stat;
  logic              we_work, we_workoe;

  always_comb begin
    we_ctrl   = wr_en_i && (wr_addr_i == ADR_CTRL);
    we_rate   = wr_en_i && (wr_addr_i == ADR_RATE);
    we_bits   = wr_en_i && (wr_addr_i == ADR_BITS);
    we_prep   = wr_en_i && (wr_addr_i == ADR_PREP);
    we_prepoe = wr_en_i && (wr_addr_i == ADR_PREPOE);
    we_stat   = wr_en_i && (wr_addr_i == ADR_STAT);
    we_work   = wr_en_i && (wr_addr_i == ADR_WORK) && !run_q;
    we_workoe = wr_en_i && (wr_addr_i == ADR_WORKOE) && !run_q;
  end

  bsl_rate_div #(.RATE_W(RATE_W)) rate_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .run_i(run_q), .preset_i(rate_q),
    .strobe_o(strobe), .sclk_o(shift_clk_o)
  );

  bsl_bit_count #(.CNT_W(CNT_W)) count_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .run_i(run_q), .strobe_i(strobe),
    .preset_i(bits_q), .last_o(swap)
  );

  bsl_shift_core #(.DATA_W(DATA_W)) core_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .run_i(run_q), .cap_i(cap_q),
    .strobe_i(strobe), .last_i(swap), .pin_i(pin_in_i),
    .ld_data_i(we_work), .ld_oe_i(we_workoe), .ld_val_i(wr_data_i),
    .prep_i(prep_q), .prep_oe_i(prepoe_q),
    .work_o(work), .work_oe_o(work_oe), .cap_word_o(cap_word),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
  );

  always_comb begin
    run_d    = we_ctrl ? wr_data_i[CTRL_RUN] : run_q;
    cap_d    = we_ctrl ? wr_data_i[CTRL_CAP] : cap_q;
    rate_d   = we_rate ? wr_data_i[RATE_W-1:0] : rate_q;
    bits_d   = we_bits ? wr_data_i[CNT_W-1:0] : bits_q;
    prepoe_d = we_prepoe ? wr_data_i : prepoe_q;
    prep_d   = prep_q;
    if (swap && cap_q) prep_d = cap_word;
    else if (we_prep)  prep_d = wr_data_i;
    pend_d = pend_q;
    if (we_prep)               pend_d = 1'b1;
    else if (swap && !cap_q)   pend_d = 1'b0;
    done_d = (done_q && !(we_stat && wr_data_i[ST_DONE])) || swap;
    und_d  = (und_q && !(we_stat && wr_data_i[ST_UNDER])) ||
             (swap && !cap_q && !pend_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q    <= 1'b0;
      cap_q    <= 1'b0;
      rate_q   <= '0;
      bits_q   <= '0;
      prep_q   <= '0;
      prepoe_q <= '0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      und_q    <= 1'b0;
    end else begin
      run_q    <= run_d;
      cap_q    <= cap_d;
      rate_q   <= rate_d;
      bits_q   <= bits_d;
      prep_q   <= prep_d;
      prepoe_q <= prepoe_d;
      pend_q   <= pend_d;
      done_q   <= done_d;
      und_q    <= und_d;
    end
  end

  assign done_irq_o = done_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADR_CTRL:   begin rd_data_o[CTRL_RUN] = run_q; rd_data_o[CTRL_CAP] = cap_q; end
      ADR_RATE:   rd_data_o[RATE_W-1:0] = rate_q;
      ADR_BITS:   rd_data_o[CNT_W-1:0] = bits_q;
      ADR_PREP:   rd_data_o = prep_q;
      ADR_PREPOE: rd_data_o = prepoe_q;
      ADR_STAT:   begin
        rd_data_o[ST_DONE]  = done_q;
        rd_data_o[ST_UNDER] = und_q;
        rd_data_o[ST_PEND]  = pend_q;
      end
      ADR_WORK:   rd_data_o = work;
      ADR_WORKOE: rd_data_o = work_oe;
      default:    rd_data_o = '0;
    endcase
  end

  // R9: a word end always leaves the done flag set
  assert_done_on_swap_R9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    swap |=> done_irq_o);
  // R7: transmit word end without a refill flags underrun
  assert_underrun_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (swap && !cap_q && !pend_q) |=> und_q);
  // R6: a consumed refill clears the pending bit
  assert_pend_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (swap && !cap_q && !we_prep) |=> !pend_q);
endmodule

// File: tb/pin_stream_slice_tb_top.sv
module pin_stream_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        pin_in, pin_out, pin_oe, sclk, irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pin_stream_slice dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
    .shift_clk_o(sclk), .done_irq_o(irq)
  );

  // reference model state
  logic        m_run, m_cap, m_sclk, m_done, m_und, m_pend;
  logic [15:0] m_rate, m_rcnt;
  logic [4:0]  m_bits, m_bcnt;
  logic [31:0] m_work, m_woe, m_prep, m_poe;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_cap = 0; m_sclk = 0; m_done = 0; m_und = 0; m_pend = 0;
    m_rate = 0; m_rcnt = 0; m_bits = 0; m_bcnt = 0;
    m_work = 0; m_woe = 0; m_prep = 0; m_poe = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, m_cap, m_run};
      3'd1: return {16'd0, m_rate};
      3'd2: return {27'd0, m_bits};
      3'd3: return m_prep;
      3'd4: return m_poe;
      3'd5: return {29'd0, m_pend, m_und, m_done};
      3'd6: return m_work;
      default: return m_woe;
    endcase
  endfunction

  task automatic compare_all();
    string t;
    chk("R4 pin_out", {31'd0, pin_out}, {31'd0, !m_cap && m_work[31]});
    chk("R5 pin_oe", {31'd0, pin_oe}, {31'd0, m_run && !m_cap && m_woe[31]});
    chk("R2 shift_clk", {31'd0, sclk}, {31'd0, m_sclk});
    chk("R9 done_irq", {31'd0, irq}, {31'd0, m_done});
    case (rd_addr)
      3'd3:    t = "R6/R8 read";
      3'd5:    t = "R7/R9 read";
      3'd6, 3'd7: t = "R3/R10 read";
      default: t = "R11 read";
    endcase
    chk(t, rd_data, model_read(rd_addr));
  endtask

  task automatic tick();
    logic        st, lst, wp;
    logic [15:0] n_rcnt;
    logic [4:0]  n_bcnt;
    logic [31:0] n_work, n_woe, n_prep, capw;
    logic        n_sclk, n_pend, n_done, n_und;
    st   = m_run && (m_rcnt == 0);
    lst  = st && (m_bcnt == 0);
    wp   = wr_en && wr_addr == 3'd3;
    capw = {m_work[30:0], pin_in};
    n_rcnt = (!m_run || st) ? m_rate : m_rcnt - 16'd1;
    n_sclk = !m_run ? 1'b0 : (st ? !m_sclk : m_sclk);
    n_bcnt = (!m_run || lst) ? m_bits : (st ? m_bcnt - 5'd1 : m_bcnt);
    n_work = m_work; n_woe = m_woe;
    if (wr_en && wr_addr == 3'd6 && !m_run) n_work = wr_data;
    if (wr_en && wr_addr == 3'd7 && !m_run) n_woe = wr_data;
    if (st) begin
      if (m_cap) n_work = lst ? 32'd0 : capw;
      else if (lst) begin n_work = m_prep; n_woe = m_poe; end
      else begin n_work = m_work << 1; n_woe = m_woe << 1; end
    end
    n_prep = m_prep;
    if (lst && m_cap) n_prep = capw;
    else if (wp) n_prep = wr_data;
    n_pend = wp ? 1'b1 : ((lst && !m_cap) ? 1'b0 : m_pend);
    n_done = (m_done && !(wr_en && wr_addr == 3'd5 && wr_data[0])) || lst;
    n_und  = (m_und && !(wr_en && wr_addr == 3'd5 && wr_data[1])) || (lst && !m_cap && !m_pend);
    @(posedge clk);
    if (wr_en && wr_addr == 3'd0) begin m_run = wr_data[0]; m_cap = wr_data[1]; end
    if (wr_en && wr_addr == 3'd1) m_rate = wr_data[15:0];
    if (wr_en && wr_addr == 3'd2) m_bits = wr_data[4:0];
    if (wr_en && wr_addr == 3'd4) m_poe = wr_data;
    m_rcnt = n_rcnt; m_sclk = n_sclk; m_bcnt = n_bcnt;
    m_work = n_work; m_woe = n_woe; m_prep = n_prep;
    m_pend = n_pend; m_done = n_done; m_und = n_und;
    @(negedge clk);
    compare_all();
    rd_addr = rd_addr + 3'd1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; pin_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state on the ports
    chk("R1 pin_out", {31'd0, pin_out}, 32'd0);
    chk("R1 pin_oe", {31'd0, pin_oe}, 32'd0);
    chk("R1 shift_clk", {31'd0, sclk}, 32'd0);
    chk("R1 done_irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    idle(3);
    for (int a = 0; a < 8; a++) begin
      rd_addr = a[2:0];
      #1 chk("R1 readback", rd_data, 32'd0);
    end

    // transmit with prescale 2, 8-bit words
    wr(3'd1, 32'd2);
    wr(3'd2, 32'd7);
    wr(3'd6, 32'hA5C3_0000);
    wr(3'd7, 32'hF0FF_0000);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'h3C81_0000);
    wr(3'd0, 32'd1);
    idle(30);
    wr(3'd3, 32'h9955_0000);
    idle(30);
    // R10: working-register writes ignored while running
    wr(3'd6, 32'h1234_5678);
    wr(3'd7, 32'h0000_0000);
    idle(40);
    wr(3'd5, 32'd3);
    idle(4);
    wr(3'd0, 32'd0);
    idle(3);

    // capture, full rate, 32-bit words
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd31);
    wr(3'd0, 32'd3);
    for (int i = 0; i < 80; i++) begin
      pin_in = ((i % 3) == 0) ^ (i[4]);
      tick();
    end
    wr(3'd0, 32'd0);

    // one-bit words at full rate with a refill every cycle
    wr(3'd2, 32'd0);
    wr(3'd6, 32'h8000_0000);
    wr(3'd7, 32'h8000_0000);
    wr(3'd0, 32'd1);
    for (int i = 0; i < 24; i++) wr(3'd3, {i[0], 31'd0} ^ 32'h4000_0000);
    idle(6);
    wr(3'd5, 32'd1);
    wr(3'd0, 32'd0);

    // random register traffic
    for (int i = 0; i < 6000; i++) begin
      pin_in  = $urandom_range(0, 1);
      rd_addr = $urandom_range(0, 7);
      if ($urandom_range(0, 9) < 3) begin
        wr_en   = 1'b1;
        wr_addr = $urandom_range(0, 7);
        wr_data = $urandom;
        if (wr_addr == 3'd1) wr_data = wr_data & 32'h3;
        if (wr_addr == 3'd0 && $urandom_range(0, 3) != 0) wr_data[0] = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      tick();
    end
    wr_en = 1'b0;
    idle(4);
    finish_run();
  end
endmodule